// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a slave device has left stuck, typically because the system was reset while the slave was driving SDA low in the middle of a byte. When launched, it sends a train of SCL clock pulses with SDA left floating. Each pulse lets the stuck slave shift out one more bit, until it reaches an acknowledge slot and lets go of the bus. The block then closes with a STOP condition, so every device on the bus goes back to idle.

Both bus lines are handled in open-drain fashion. The block never drives a line high. A high level is obtained by disabling the pull-low driver and letting the external pull-up raise the line. A low level is obtained by enabling the pull-low driver. All phase timing is counted in quarter-period ticks. The length of a tick, in system clock cycles, comes from a divisor input that is captured when the sequence is launched. At a 50 MHz clock, a divisor of 250 gives a 5 µs tick.

Top module: `i2c_unstick`

## Requirements
- R1: After reset the block is idle: busy_o and done_o are 0 and neither pull-low driver is enabled.
- R2: Whenever busy_o is 0, both SCL and SDA are released (pull-low disabled). A released line stands for logic 1 and a driven line for logic 0.
- R3: A start_i pulse seen while idle raises busy_o and pulls SCL low in the very next cycle. SDA stays released at that point.
- R4: Exactly 9 SCL pulses (a low phase followed by a high phase) are issued, and SDA stays released throughout all of them.
- R5: Each SCL low phase and each SCL high phase lasts exactly 2 ticks. A tick is D clock cycles, where D is the captured divisor.
- R6: After the ninth pulse a STOP follows, with one tick per step, in this order: SCL low with SDA released, then SDA low, then SCL released, then SDA released. SDA only ever falls while SCL is held low.
- R7: After the final STOP step (40 ticks after launch), busy_o falls and done_o is 1 for exactly one cycle. Both lines are left released.
- R8: A start_i pulse while busy_o is 1 is ignored. The running sequence keeps its exact timing, and no second sequence follows.
- R9: The divisor is sampled only at launch. Changing quarter_div_i during a sequence does not alter its timing.
- R10: A divisor value of 0 is treated as 1, giving a one-cycle tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch request, a one-cycle pulse |
| quarter_div_i | input | DIV_W | Clock cycles per quarter-period tick (0 is treated as 1) |
| busy_o | output | 1 | Recovery sequence in progress |
| done_o | output | 1 | One-cycle pulse when the sequence completes |
| scl_pull_low_o | output | 1 | Enables the open-drain pull-low driver on SCL |
| sda_pull_low_o | output | 1 | Enables the open-drain pull-low driver on SDA |

## Verification
Take the launch edge as cycle 0 and let D be the captured divisor. The line state for each cycle k after launch then follows from the tick index k/D. Indices 0 to 35 form the nine pulses: the first two ticks of each group of four are low and the last two are high. Indices 36 to 39 are the four STOP steps. At cycle 40·D the done pulse appears and busy falls. The bench samples at every falling clock edge from cycle 0 through 40·D+1 and compares all four outputs against this formula. It repeats this for several divisors, including 0, 1 and the 5 µs value. It also injects a second start or a divisor change partway through a run, to show that the timeline does not shift.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_CLK_LO,
      PH_CLK_HI,
      PH_STOP_A,
      PH_STOP_B,
      PH_STOP_C,
      PH_STOP_D
   } phase_e;
endpackage

// File: rtl/i2c_unstick_tick.sv
module i2c_unstick_tick #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             run_i,
   output logic             tick_o
);
   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   generate
      if (DIV_W < 1) begin : g_bad_w
         $error("DIV_W must be at least 1");
      end
   endgenerate

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] cnt_q;

   assign tick_o = run_i && (cnt_q == div_q - ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= ONE;
         cnt_q <= '0;
      end else if (load_i) begin
         div_q <= (div_i == '0) ? ONE : div_i;
         cnt_q <= '0;
      end else if (run_i) begin
         if (tick_o) cnt_q <= '0;
         else        cnt_q <= cnt_q + ONE;
      end
   end

   // R9: captured divisor holds for the whole run
   a_r9_div_held: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !load_i) |=> (load_i || $stable(div_q)));

   // R10: captured divisor is never zero
   a_r10_div_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      div_q != '0);
endmodule

// File: rtl/i2c_unstick_fsm.sv
module i2c_unstick_fsm
   import i2c_unstick_pkg::*;
#(
   parameter int NUM_PULSES = 9,
   parameter int LO_TICKS   = 2,
   parameter int HI_TICKS   = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start_i,
   input  logic   tick_i,
   output phase_e phase_o,
   output logic   load_o,
   output logic   busy_o,
   output logic   done_o
);
   localparam int MAX_TICKS = (LO_TICKS > HI_TICKS) ? LO_TICKS : HI_TICKS;
   localparam int TCNT_W    = $clog2(MAX_TICKS + 1);
   localparam int PCNT_W    = $clog2(NUM_PULSES + 1);

   generate
      if (NUM_PULSES < 1) begin : g_bad_pulses
         $error("NUM_PULSES must be at least 1");
      end
      if (LO_TICKS < 1 || HI_TICKS < 1) begin : g_bad_ticks
         $error("phase lengths must be at least one tick");
      end
   endgenerate

   phase_e            phase_q;
   logic [TCNT_W-1:0] tcnt_q;
   logic [PCNT_W-1:0] pcnt_q;
   logic              done_q;
   logic [TCNT_W-1:0] len;
   logic              last_tick;

   always_comb begin
      case (phase_q)
         PH_CLK_LO: len = TCNT_W'(LO_TICKS);
         PH_CLK_HI: len = TCNT_W'(HI_TICKS);
         default:   len = TCNT_W'(1);
      endcase
   end

   assign last_tick = tick_i && (tcnt_q == len - TCNT_W'(1));
   assign load_o    = start_i && (phase_q == PH_IDLE);
   assign busy_o    = (phase_q != PH_IDLE);
   assign done_o    = done_q;
   assign phase_o   = phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         tcnt_q  <= '0;
         pcnt_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (load_o) begin
            phase_q <= PH_CLK_LO;
            tcnt_q  <= '0;
            pcnt_q  <= '0;
         end else if (busy_o && tick_i) begin
            if (!last_tick) begin
               tcnt_q <= tcnt_q + TCNT_W'(1);
            end else begin
               tcnt_q <= '0;
               case (phase_q)
                  PH_CLK_LO: phase_q <= PH_CLK_HI;
                  PH_CLK_HI: begin
                     if (pcnt_q == PCNT_W'(NUM_PULSES - 1)) phase_q <= PH_STOP_A;
                     else                                   phase_q <= PH_CLK_LO;
                     pcnt_q <= pcnt_q + PCNT_W'(1);
                  end
                  PH_STOP_A: phase_q <= PH_STOP_B;
                  PH_STOP_B: phase_q <= PH_STOP_C;
                  PH_STOP_C: phase_q <= PH_STOP_D;
                  PH_STOP_D: begin
                     phase_q <= PH_IDLE;
                     done_q  <= 1'b1;
                  end
                  default:   phase_q <= PH_IDLE;
               endcase
            end
         end
      end
   end

   // R7: done is a single-cycle pulse raised as busy falls
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r7_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   // R3: an accepted start launches at once
   a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && phase_o == PH_CLK_LO));

   // R8: start while busy does not restart the pulse count
   a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !tick_i) |=> $stable(pcnt_q));
endmodule

// File: rtl/i2c_unstick_lines.sv
module i2c_unstick_lines
   import i2c_unstick_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  phase_e phase_i,
   output logic   scl_low_o,
   output logic   sda_low_o
);
   always_comb begin
      scl_low_o = 1'b0;
      sda_low_o = 1'b0;
      case (phase_i)
         PH_CLK_LO: scl_low_o = 1'b1;
         PH_STOP_A: scl_low_o = 1'b1;
         PH_STOP_B: begin scl_low_o = 1'b1; sda_low_o = 1'b1; end
         PH_STOP_C: sda_low_o = 1'b1;
         default:   ;
      endcase
   end

   // R4: SDA left floating while the clock pulses run
   a_r4_sda_free_pulses: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_i == PH_CLK_LO || phase_i == PH_CLK_HI) |-> !sda_low_o);

   // R6: SDA only falls while SCL is held low
   a_r6_sda_falls_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_low_o) |-> scl_low_o);

   // R2: idle leaves both lines released
   a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_i == PH_IDLE) |-> (!scl_low_o && !sda_low_o));
endmodule

// File: rtl/i2c_unstick.sv
module i2c_unstick
   import i2c_unstick_pkg::*;
#(
   parameter int DIV_W      = 16,
   parameter int NUM_PULSES = 9,
   parameter int LO_TICKS   = 2,
   parameter int HI_TICKS   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [DIV_W-1:0] quarter_div_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             scl_pull_low_o,
   output logic             sda_pull_low_o
);
   phase_e phase;
   logic   load;
   logic   tick;

   i2c_unstick_tick #(.DIV_W(DIV_W)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .div_i  (quarter_div_i),
      .run_i  (busy_o),
      .tick_o (tick)
   );

   i2c_unstick_fsm #(
      .NUM_PULSES (NUM_PULSES),
      .LO_TICKS   (LO_TICKS),
      .HI_TICKS   (HI_TICKS)
   ) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .tick_i  (tick),
      .phase_o (phase),
      .load_o  (load),
      .busy_o  (busy_o),
      .done_o  (done_o)
   );

   i2c_unstick_lines u_lines (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase_i   (phase),
      .scl_low_o (scl_pull_low_o),
      .sda_low_o (sda_pull_low_o)
   );

   // R2: outside a sequence no driver is enabled
   a_r2_released_when_free: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!scl_pull_low_o && !sda_pull_low_o));
endmodule

// File: tb/i2c_unstick_tb_top.sv
module i2c_unstick_tb_top;
   localparam int DIV_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [DIV_W-1:0] quarter_div_i = '0;
   logic             busy_o, done_o, scl_pull_low_o, sda_pull_low_o;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   i2c_unstick #(.DIV_W(DIV_W)) dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_i        (start_i),
      .quarter_div_i  (quarter_div_i),
      .busy_o         (busy_o),
      .done_o         (done_o),
      .scl_pull_low_o (scl_pull_low_o),
      .sda_pull_low_o (sda_pull_low_o)
   );

   task automatic check4(input string req, input int t,
                         input logic eb, input logic ed, input logic es, input logic ea);
      checks++;
      if (busy_o !== eb || done_o !== ed || scl_pull_low_o !== es || sda_pull_low_o !== ea) begin
         errors++;
         $display("FAIL %s t=%0d busy/done/scl/sda actual %b%b%b%b expected %b%b%b%b",
                  req, t, busy_o, done_o, scl_pull_low_o, sda_pull_low_o, eb, ed, es, ea);
      end
   endtask

   // R1: reset state
   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check4("R1", -1, 1'b0, 1'b0, 1'b0, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check4("R2", -1, 1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   // one full sequence; inject_at >= 0 pulses start (R8) and changes the divisor (R9)
   task automatic t_run(input int div, input int inject_at);
      int d;
      int rises;
      logic prev_scl;
      d = (div == 0) ? 1 : div;  // R10
      rises = 0;
      prev_scl = 1'b0;
      quarter_div_i = DIV_W'(div);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i <= 40 * d + 1; i++) begin
         int q;
         logic es, ea;
         string req;
         q = i / d;
         if (i >= 40 * d) begin
            es = 1'b0; ea = 1'b0;
            req = (i == 40 * d) ? "R7" : "R7 R8";
            check4(req, i, 1'b0, (i == 40 * d), es, ea);
         end else begin
            if (q < 36) begin
               es = ((q % 4) < 2);
               ea = 1'b0;
               req = (i == 0) ? "R3" : ((inject_at >= 0) ? "R8 R9 R5" : "R4 R5");
            end else begin
               es = (q - 36) < 2;
               ea = (q == 37) || (q == 38);
               req = "R6";
            end
            if (div == 0) req = {req, " R10"};
            check4(req, i, 1'b1, 1'b0, es, ea);
         end
         if (prev_scl && !scl_pull_low_o) rises++;
         prev_scl = scl_pull_low_o;
         if (i == inject_at) begin
            start_i = 1'b1;
            quarter_div_i = DIV_W'(d + 3);
         end else begin
            start_i = 1'b0;
         end
         @(negedge clk);
      end
      checks++;
      if (rises != 10) begin  // R4: 9 pulses plus the STOP release
         errors++;
         $display("FAIL R4 SCL releases actual %0d expected 10", rises);
      end
      quarter_div_i = '0;
   endtask

   initial begin
      t_reset();
      t_run(3, -1);
      t_run(1, -1);
      t_run(0, -1);
      t_run(2, 13);
      t_run(4, 150);
      t_run(250, 777);
      t_reset();
      t_run(5, -1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule